// File: doc/BRIEF.md
# Asymmetric Width Dual-Clock FIFO

This block moves a data stream from one clock domain to another when the producer and the consumer use different word widths. The wider port is a power-of-two multiple of the narrower one, in either direction. Storage is kept as an array of narrow slices. Each side keeps its own pointer in units of its own word. These pointers cross the clock boundary in Gray code through two-flop synchronizers. Each side then scales the pointer from the other side to narrow units before it compares the two.

The write side is a valid/ready stream. A word is taken on a write-clock edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverse of `wr_full`, and it does not depend on `wr_valid`, so the producer may hold a word as long as it likes. The behaviour of the read side depends on a build-time mode:

- **Fall-through mode:** the oldest whole word is presented on `rd_data` with `rd_valid` high. It is held stable until `rd_ready` is high on a read-clock edge.
- **Standard mode:** `rd_ready` acts as a read request. A request made while `rd_empty` is low is served, and the word appears on `rd_data` one read-clock cycle later, marked by a one-cycle `rd_valid` pulse.

Both flags count only whole words of their own port, so slices of a partly assembled word can sit inside the FIFO while `rd_empty` is high.

Top module: `asym_cdc_fifo`

## Requirements
- R1: When the write port is narrower, the first narrow word written lands in bits [NW-1:0] of the wide word that is read, and later narrow words fill the slices above it in order. When the write port is wider, bits [NW-1:0] of a written word are read out first. NW is the narrower width.
- R2: `rd_empty` stays high while fewer narrow slices than one read word are stored, even if some slices are present.
- R3: A write is accepted only on a write-clock edge with `wr_valid` and `wr_ready` both high, and `wr_ready` equals the inverse of `wr_full`. A write attempted while full changes neither the contents nor the write pointer.
- R4: `wr_full` is high when the free space is less than one write word. In the narrow-write case, once one wide word is read out of a full FIFO, `wr_full` falls and RD_W/WR_W writes are needed to raise it again. With 8-bit writes and 32-bit reads, one write is not enough and four writes are.
- R5: In the wide-write case, `wr_full` stays high until WR_W/RD_W narrow reads have freed a whole write word. With 32-bit writes and 8-bit reads, one read is not enough and four reads are.
- R6: The storage holds 2^AW narrow slices. Fall-through mode adds one read word held in the output stage. With 8-bit writes, 32-bit reads and AW=6, exactly 68 writes are accepted with no reads. With 32-bit writes, 8-bit reads, AW=6 and standard mode, exactly 16 writes are accepted.
- R7: In fall-through mode, a word is presented with `rd_valid` high without any request. It stays stable while `rd_valid` is high and `rd_ready` is low. `rd_empty` equals the inverse of `rd_valid`.
- R8: In standard mode, a read is accepted on a read-clock edge with `rd_ready` high and `rd_empty` low. `rd_valid` is high exactly in the following cycle, carrying that word, and is low otherwise.
- R9: A standard-mode read requested while `rd_empty` is high produces no `rd_valid` and consumes nothing.
- R10: While `rst_n` is low, `wr_full` and `rd_empty` are high and `rd_valid` is low. After release, an empty FIFO shows `wr_full` low.
- R11: Under arbitrary interleaving of writes and reads on unrelated clocks, every accepted slice is read exactly once, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | WR_W | Write word |
| wr_ready | output | 1 | A write is taken this edge if `wr_valid` is high |
| wr_full | output | 1 | Less than one write word of free space |
| rd_ready | input | 1 | Consumer accepts (fall-through mode) or requests (standard mode) |
| rd_data | output | RD_W | Read word |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_empty | output | 1 | No whole read word is available |

## Verification
A corrupted pointer or a lost synchronizer update shows up at the ports as a flag that is wrong for good, not just late. The symptoms are a `wr_full` that never clears, a word that comes out twice, or a slice that is skipped, and any of these breaks the byte order on the very next read word. Flags are therefore checked a dozen cycles after the traffic stops, well past the synchronizer delay. A packing slip shows up at once, as slices in the wrong position in the first word read. Capacity errors shift the count of accepted writes at the full boundary by one word.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic {
    RD_MODE_STD  = 1'b0,
    RD_MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/afifo_gray_sync.sv
module afifo_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the parity of the Gray bits at and above it.
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_g2b
      assign bin_out[i] = ^(stab_q >> i);
    end
  endgenerate
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
  parameter int AW  = 6,
  parameter int WSH = 0,
  parameter int RSH = 2
) (
  input  logic            wr_clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-RSH:0] rgray,
  output logic [AW-WSH:0] wgray,
  output logic [AW-1:0]   waddr,
  output logic [AW:0]     used,
  output logic            push,
  output logic            full
);
  localparam int WAW = AW - WSH;
  localparam int RAW = AW - RSH;
  localparam logic [AW:0] DEPTH_N = (AW+1)'(1 << AW);
  localparam logic [AW:0] WR_STEP = (AW+1)'(1 << WSH);

  logic [WAW:0] wbin, wbin_nx;
  logic [RAW:0] rbin_s;
  logic [AW:0]  wn, rn, free_n;

  afifo_gray_sync #(.W(RAW+1)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
  );

  assign wn      = (AW+1)'(wbin) << WSH;
  assign rn      = (AW+1)'(rbin_s) << RSH;
  assign used    = wn - rn;
  assign free_n  = DEPTH_N - used;
  assign full    = !rst_n || (free_n < WR_STEP);
  assign push    = wr_valid && !full;
  assign waddr   = wn[AW-1:0];
  assign wbin_nx = wbin + (WAW+1)'(1);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int       AW   = 6,
  parameter int       WSH  = 0,
  parameter int       RSH  = 2,
  parameter int       RD_W = 32,
  parameter rd_mode_e MODE = RD_MODE_FWFT
) (
  input  logic            rd_clk,
  input  logic            rst_n,
  input  logic            rd_ready,
  input  logic [AW-WSH:0] wgray,
  input  logic [RD_W-1:0] mem_rdata,
  output logic [AW-RSH:0] rgray,
  output logic [AW-1:0]   raddr,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            rd_empty
);
  localparam int WAW = AW - WSH;
  localparam int RAW = AW - RSH;
  localparam logic [AW:0] RD_STEP = (AW+1)'(1 << RSH);

  logic [RAW:0] rbin, rbin_nx;
  logic [WAW:0] wbin_s;
  logic [AW:0]  wn, rn, avail;
  logic         mem_empty, pop, vld_q, vld_nx;

  afifo_gray_sync #(.W(WAW+1)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
  );

  assign wn        = (AW+1)'(wbin_s) << WSH;
  assign rn        = (AW+1)'(rbin) << RSH;
  assign avail     = wn - rn;
  assign mem_empty = avail < RD_STEP;
  assign raddr     = rn[AW-1:0];
  assign rbin_nx   = rbin + (RAW+1)'(1);

  generate
    if (MODE == RD_MODE_FWFT) begin : g_fwft
      assign pop      = !mem_empty && (!vld_q || rd_ready);
      assign vld_nx   = pop || (vld_q && !rd_ready);
      assign rd_empty = !vld_q;
    end else begin : g_std
      assign pop      = !mem_empty && rd_ready;
      assign vld_nx   = pop;
      assign rd_empty = mem_empty;
    end
  endgenerate

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      vld_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      vld_q <= vld_nx;
      if (pop) begin
        rbin    <= rbin_nx;
        rgray   <= rbin_nx ^ (rbin_nx >> 1);
        rd_data <= mem_rdata;
      end
    end
  end

  assign rd_valid = vld_q;
endmodule

// File: rtl/asym_cdc_fifo.sv
module asym_cdc_fifo
  import afifo_pkg::*;
#(
  parameter int       WR_W = 8,
  parameter int       RD_W = 32,
  parameter int       AW   = 6,
  parameter rd_mode_e MODE = RD_MODE_FWFT
) (
  input  logic            wr_clk,
  input  logic            rd_clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [WR_W-1:0] wr_data,
  output logic            wr_ready,
  output logic            wr_full,
  input  logic            rd_ready,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            rd_empty
);
  localparam int NW       = (WR_W < RD_W) ? WR_W : RD_W;
  localparam int WR_RATIO = WR_W / NW;
  localparam int RD_RATIO = RD_W / NW;
  localparam int WSH      = $clog2(WR_RATIO);
  localparam int RSH      = $clog2(RD_RATIO);
  localparam int DEPTH    = 1 << AW;

  logic [AW-WSH:0] wr_gray_w;
  logic [AW-RSH:0] rd_gray_w;
  logic [AW-1:0]   waddr, raddr;
  logic [AW:0]     wr_used_w;
  logic            push;
  logic [RD_W-1:0] mem_rdata;
  logic [NW-1:0]   mem [DEPTH];

  afifo_wr_ctl #(.AW(AW), .WSH(WSH), .RSH(RSH)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .rgray(rd_gray_w),
    .wgray(wr_gray_w), .waddr(waddr), .used(wr_used_w), .push(push), .full(wr_full)
  );

  afifo_rd_ctl #(.AW(AW), .WSH(WSH), .RSH(RSH), .RD_W(RD_W), .MODE(MODE)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_ready(rd_ready), .wgray(wr_gray_w),
    .mem_rdata(mem_rdata), .rgray(rd_gray_w), .raddr(raddr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  assign wr_ready = !wr_full;

  // Slice k of a write word goes to the k-th narrow slot, lowest slice first.
  always_ff @(posedge wr_clk) begin
    if (push) begin
      for (int k = 0; k < WR_RATIO; k++) begin
        mem[waddr + AW'(k)] <= wr_data[k*NW +: NW];
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < RD_RATIO; k++) begin : g_rd_slice
      assign mem_rdata[k*NW +: NW] = mem[raddr + AW'(k)];
    end
  endgenerate
endmodule

// File: rtl/asym_cdc_fifo_chk.sv
module asym_cdc_fifo_chk
  import afifo_pkg::*;
#(
  parameter int       AW   = 6,
  parameter int       WSH  = 0,
  parameter int       RSH  = 2,
  parameter int       RD_W = 32,
  parameter rd_mode_e MODE = RD_MODE_FWFT
) (
  input logic            wr_clk,
  input logic            rd_clk,
  input logic            rst_n,
  input logic            wr_full,
  input logic            wr_ready,
  input logic [AW:0]     wr_used,
  input logic [AW-WSH:0] wr_gray,
  input logic [AW-RSH:0] rd_gray,
  input logic            rd_ready,
  input logic            rd_valid,
  input logic            rd_empty,
  input logic [RD_W-1:0] rd_data
);
  localparam logic [AW:0] DEPTH_N = (AW+1)'(1 << AW);

  assert_full_in_reset_R10: assert property (@(posedge wr_clk) !rst_n |-> wr_full);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |=> $stable(wr_gray));

  assert_used_bound_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_used <= DEPTH_N);

  generate
    if (MODE == RD_MODE_FWFT) begin : g_fwft
      assert_hold_stall_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
      assert_empty_flag_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty != rd_valid);
    end else begin : g_std
      assert_valid_latency_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_ready && !rd_empty));
      assert_no_underflow_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty |=> $stable(rd_gray) && !rd_valid);
    end
  endgenerate
endmodule

bind asym_cdc_fifo asym_cdc_fifo_chk #(
  .AW(AW), .WSH(WSH), .RSH(RSH), .RD_W(RD_W), .MODE(MODE)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_full(wr_full),
  .wr_ready(wr_ready), .wr_used(wr_used_w), .wr_gray(wr_gray_w),
  .rd_gray(rd_gray_w), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_empty(rd_empty), .rd_data(rd_data)
);

// File: tb/asym_cdc_fifo_bench.sv
`timescale 1ns/1ps
module asym_cdc_fifo_bench;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  always #10 wr_clk = ~wr_clk;
  always #7  rd_clk = ~rd_clk;

  // Narrow write, wide read, fall-through
  logic        wv_a = 0, wrdy_a, wfull_a, rr_a = 0, rv_a, re_a;
  logic [7:0]  wd_a = 0;
  logic [31:0] rd_a;
  // Wide write, narrow read, standard
  logic        wv_b = 0, wrdy_b, wfull_b, rr_b = 0, rv_b, re_b;
  logic [31:0] wd_b = 0;
  logic [7:0]  rd_b;

  asym_cdc_fifo u_asym_cdc_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wv_a), .wr_data(wd_a),
    .wr_ready(wrdy_a), .wr_full(wfull_a), .rd_ready(rr_a), .rd_data(rd_a),
    .rd_valid(rv_a), .rd_empty(re_a));

  asym_cdc_fifo #(.WR_W(32), .RD_W(8), .AW(6), .MODE(afifo_pkg::RD_MODE_STD)) u_asym_cdc_fifo_wide (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wv_b), .wr_data(wd_b),
    .wr_ready(wrdy_b), .wr_full(wfull_b), .rd_ready(rr_b), .rd_data(rd_b),
    .rd_valid(rv_b), .rd_empty(re_b));

  logic [7:0] qa[$];
  logic [7:0] qb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected wide word: oldest byte in the least significant slice (R1).
  function automatic logic [31:0] pack_next4();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = qa.pop_front();
    return w;
  endfunction

  task automatic a_wr(bit v, logic [7:0] d);
    @(negedge wr_clk);
    wv_a = v; wd_a = d;
    if (v && wrdy_a) qa.push_back(d);
    @(posedge wr_clk); #1 wv_a = 0;
  endtask

  task automatic a_rd(bit r);
    logic [31:0] exp;
    @(negedge rd_clk);
    rr_a = r;
    if (r && rv_a) begin
      if (qa.size() < 4) chk(0, "R11 read with no whole word written", rd_a, 0);
      else begin
        exp = pack_next4();
        chk(rd_a == exp, "R1/R11 wide word order", rd_a, exp);
      end
    end
    @(posedge rd_clk); #1 rr_a = 0;
  endtask

  task automatic b_wr(bit v, logic [31:0] d);
    @(negedge wr_clk);
    wv_b = v; wd_b = d;
    if (v && wrdy_b) for (int k = 0; k < 4; k++) qb.push_back(d[k*8 +: 8]);
    @(posedge wr_clk); #1 wv_b = 0;
  endtask

  task automatic b_rd(bit r);
    bit acc;
    logic [7:0] exp;
    @(negedge rd_clk);
    rr_b = r;
    acc = r && !re_b;
    @(posedge rd_clk); #1 rr_b = 0;
    @(negedge rd_clk);
    chk(rv_b == acc, "R8/R9 valid one cycle after accepted read", rv_b, acc);
    if (acc && rv_b) begin
      exp = (qb.size() > 0) ? qb.pop_front() : 8'hxx;
      chk(rd_b === exp, "R1/R11 narrow slice order", rd_b, exp);
    end
  endtask

  task automatic wait_w(int n); repeat (n) @(posedge wr_clk); endtask
  task automatic wait_r(int n); repeat (n) @(posedge rd_clk); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #35;
    // R10: reset state
    chk(wfull_a == 1 && wfull_b == 1, "R10 full held in reset", {wfull_a, wfull_b}, 2'b11);
    chk(re_a == 1 && re_b == 1, "R10 empty in reset", {re_a, re_b}, 2'b11);
    chk(rv_a == 0 && rv_b == 0, "R10 no valid in reset", {rv_a, rv_b}, 0);
    #20 rst_n = 1;
    wait_w(4);
    chk(wfull_a == 0 && wfull_b == 0, "R10 full clear after reset", {wfull_a, wfull_b}, 0);

    // R2: partial word stays hidden
    a_wr(1, 8'h11); a_wr(1, 8'h22); a_wr(1, 8'h33);
    wait_r(12);
    chk(re_a == 1, "R2 empty with three slices stored", re_a, 1);
    a_wr(1, 8'h44);
    wait_r(12);
    chk(re_a == 0 && rv_a == 1, "R7 word falls through without request", rv_a, 1);
    chk(rd_a == 32'h4433_2211, "R1 first byte in low slice", rd_a, 32'h4433_2211);
    wait_r(5);
    chk(rd_a == 32'h4433_2211 && rv_a, "R7 held while not accepted", rd_a, 32'h4433_2211);
    a_rd(1);
    wait_r(6);
    chk(re_a == 1 && qa.size() == 0, "R7 empty after last word", re_a, 1);

    // R6/R3: fill narrow-write FIFO with no reads
    for (int i = 0; i < 80; i++) a_wr(1, 8'(i + 8'h50));
    chk(qa.size() == 68, "R6 fall-through capacity", qa.size(), 68);
    chk(wfull_a == 1 && wrdy_a == 0, "R3 ready low while full", wrdy_a, 0);
    a_rd(1);
    wait_w(12);
    chk(wfull_a == 0, "R4 one wide read clears full", wfull_a, 0);
    a_wr(1, 8'hA0);
    wait_w(12);
    chk(wfull_a == 0, "R4 one narrow write does not refill", wfull_a, 0);
    a_wr(1, 8'hA1); a_wr(1, 8'hA2); a_wr(1, 8'hA3);
    wait_w(12);
    chk(wfull_a == 1, "R4 four narrow writes refill", wfull_a, 1);
    repeat (30) a_rd(1);
    wait_r(12);
    chk(qa.size() == 0 && re_a == 1, "R3/R11 nothing extra stored after full", qa.size(), 0);

    // R9: standard reads while empty do nothing
    repeat (3) b_rd(1);
    b_wr(1, 32'hDDCC_BBAA);
    wait_r(12);
    chk(re_b == 0, "R8 empty clears after whole write", re_b, 0);
    b_rd(1);
    chk(qb.size() == 3, "R1 low slice read first", qb.size(), 3);
    repeat (3) b_rd(1);
    b_rd(1);

    // R5/R6: fill wide-write FIFO
    for (int i = 0; i < 20; i++) b_wr(1, 32'h0101_0101 * i);
    chk(qb.size() == 64, "R6 standard capacity 16 words", qb.size(), 64);
    b_rd(1);
    wait_w(12);
    chk(wfull_b == 1, "R5 one narrow read leaves full", wfull_b, 1);
    repeat (3) b_rd(1);
    wait_w(12);
    chk(wfull_b == 0, "R5 four narrow reads clear full", wfull_b, 0);
    repeat (60) b_rd(1);
    chk(qb.size() == 0 && re_b == 1, "R11 wide drain complete", qb.size(), 0);

    // R11: random traffic on both instances
    fork
      repeat (1200) a_wr(1'($urandom_range(0, 1)), 8'($urandom));
      repeat (1500) a_rd($urandom_range(0, 3) != 0);
      repeat (1200) b_wr(1'($urandom_range(0, 2) == 0), 32'($urandom));
      repeat (1500) b_rd($urandom_range(0, 2) != 0);
    join
    while (qa.size() % 4 != 0) begin
      a_wr(1, 8'($urandom));
      a_rd(1);
    end
    repeat (60) a_rd(1);
    repeat (80) b_rd(1);
    wait_r(12);
    chk(qa.size() == 0 && re_a == 1, "R11 random narrow-write drain", qa.size(), 0);
    chk(qb.size() == 0 && re_b == 1, "R11 random wide-write drain", qb.size(), 0);
    finish_run();
  end
endmodule